// File: doc/BRIEF.md
# Serial SAR Converter Digital Front-End

This block is the device-side digital logic of a four-input, 16-bit successive-approximation converter that a host reaches over a three-wire serial port. It has a serial clock, an active-low select and a data input. The block looks on the data input for a start bit. It then takes in the control fields that choose the input pairing and the power/clock mode. It drives a busy flag and shifts the 16-bit two's-complement result out most significant bit first. The analog sampler is not modelled. A bus of four 16-bit sample values stands in for the converted inputs.

All logic runs on one free-running system clock. The serial pins pass through a synchronizer and are then edge-detected. Data is taken in on serial-clock rising edges and sent out on falling edges. Two conversion paths exist. In the external path, the serial clock paces the result. In the internal path, a fixed count of system-clock cycles models the conversion, and the host reads the stored word afterwards. Output-enable signals take the place of the high-impedance states of the data and busy pins.

Top module: `sar_serial_front`

## Requirements
- R1: While select is low, the data input is sampled on serial-clock rising edges. Zeros received while no control byte is in progress are ignored. The first one is the start bit S, and the next seven bits, in order, are A2, A1, A0, an unused bit, SE, PD1, PD0. Raising select abandons a partly received byte.
- R2: With SE=1, the channel code A2A1A0 picks one input: 001→input 0, 101→input 1, 010→input 2, 110→input 3. The result is that input's sample.
- R3: With SE=0, the same code picks the positive input. The negative input is its partner (0↔1, 2↔3). The result is positive minus negative as a 16-bit two's-complement number, saturated to 0x7FFF and 0x8000.
- R4: The channel codes 000, 011, 100 and 111 give a result of zero.
- R5: In external mode, busy is high for exactly the one serial-clock period that starts at the falling edge after the rising edge carrying PD0, and is low after every other falling edge of the frame.
- R6: In external mode, the 16 result bits appear MSB first on the 16 falling edges after the one that raised busy. Later falling edges shift out zeros.
- R7: The next control byte may overlap the previous read-out. With a start bit on the 17th rising edge, the old LSB leaves on the same falling edge that raises busy for the new byte, and the new MSB follows on the next one.
- R8: While select is high, the data output enable is low and the data output is 0. In external mode the busy enable is low too. After select falls in external mode, busy is driven low.
- R9: PD1PD0 = 10 selects internal mode and 11 selects external mode. 00 and 01 keep the current mode. A newly written mode applies from the following conversion. External mode is the state after reset.
- R10: In internal mode, busy is low while the conversion runs for CONV_CYCLES system-clock cycles and goes high when the result is stored. The first falling edge with select low after that outputs the MSB, then bits 14..0. This holds even if select was high when the conversion finished.
- R11: In internal mode, the busy enable stays high while select is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sclk_i | input | 1 | Serial clock from the host |
| sel_n_i | input | 1 | Active-low select |
| sdi_i | input | 1 | Serial data in |
| smp_i | input | 64 | Four 16-bit two's-complement samples, input 0 in the low bits |
| sdo_o | output | 1 | Serial data out |
| sdo_oe_o | output | 1 | Enable for the data output (low = high impedance) |
| busy_o | output | 1 | Busy flag |
| busy_oe_o | output | 1 | Enable for the busy output (low = high impedance) |

## Verification
The hardest cases to reach from the pins both involve timing. One is a back-to-back frame where the next control byte finishes on the same falling edge that carries the previous LSB. The other is an internal-mode conversion that completes while select is high and must still read out correctly later. The bench drives a bit-stream array one serial clock at a time, with the second start bit placed on the 17th edge. It also runs a fixed frame sequence that switches clock modes and lifts select before the conversion count ends. A sweep over all eight channel codes in both input modes covers the pairing and saturation arithmetic.

// File: rtl/sarfe_pkg.sv
// Shared types and decode helpers for the serial converter front-end.
// Assumes exactly four analog inputs, as the channel code decode requires.
package sarfe_pkg;
    localparam int SARFE_NCH = 4;

    typedef enum logic [1:0] {
        PM_AUTO_OFF = 2'b00,
        PM_RSVD     = 2'b01,
        PM_INT_CLK  = 2'b10,
        PM_EXT_CLK  = 2'b11
    } pwr_mode_e;

    typedef struct packed {
        logic [2:0] sel;
        logic       single;
        pwr_mode_e  pm;
    } ctrl_t;

    // Positive-input index of a channel code: {A1, A0-independent A2}
    function automatic logic [1:0] pos_index(input logic [2:0] sel);
        return {sel[1], sel[2]};
    endfunction

    // A channel code is defined only when A1 and A0 differ
    function automatic logic code_valid(input logic [2:0] sel);
        return sel[1] ^ sel[0];
    endfunction
endpackage

// File: rtl/sarfe_pin_if.sv
// Synchronizes the serial pins into the system clock domain and derives
// serial-clock edge strobes. Assumes each serial-clock half period lasts
// more than STAGES+1 system clocks.
module sarfe_pin_if #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sclk_i,
    input  logic sel_n_i,
    input  logic sdi_i,
    output logic rise_o,
    output logic fall_o,
    output logic cs_act_o,
    output logic cs_fall_o,
    output logic din_o
);
    localparam logic [2:0] PIN_RST = 3'b010;

    logic [2:0] st_q [STAGES];
    logic       sclk_d, seln_d;
    logic       sclk_s, seln_s;

    // Synchronizer chain for {sclk, sel_n, sdi}
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) st_q[i] <= PIN_RST;
        end else begin
            st_q[0] <= {sclk_i, sel_n_i, sdi_i};
            for (int i = 1; i < STAGES; i++) st_q[i] <= st_q[i-1];
        end
    end

    assign sclk_s = st_q[STAGES-1][2];
    assign seln_s = st_q[STAGES-1][1];
    assign din_o  = st_q[STAGES-1][0];

    // Previous synchronized levels for edge detection
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_d <= 1'b0;
            seln_d <= 1'b1;
        end else begin
            sclk_d <= sclk_s;
            seln_d <= seln_s;
        end
    end

    assign cs_act_o  = !seln_s;
    assign rise_o    = sclk_s && !sclk_d && cs_act_o;
    assign fall_o    = !sclk_s && sclk_d && cs_act_o;
    assign cs_fall_o = !seln_s && seln_d;
endmodule

// File: rtl/sarfe_ctrl_rx.sv
// Hunts for the start bit on rising serial-clock strobes, gathers the seven
// control bits behind it and presents the decoded fields with a one-cycle
// done strobe. Select high abandons any partial byte.
module sarfe_ctrl_rx
    import sarfe_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  rise_i,
    input  logic  cs_act_i,
    input  logic  din_i,
    output logic  done_o,
    output ctrl_t ctrl_o
);
    localparam int FIELD_BITS = 7;
    localparam int CW         = $clog2(FIELD_BITS);

    logic                  hunting_q;
    logic [CW-1:0]         cnt_q;
    logic [FIELD_BITS-2:0] sh_q;

    // Start-bit hunt and field shift register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hunting_q <= 1'b1;
            cnt_q     <= '0;
            sh_q      <= '0;
            done_o    <= 1'b0;
            ctrl_o    <= '0;
        end else begin
            done_o <= 1'b0;
            if (!cs_act_i) begin
                hunting_q <= 1'b1;
                cnt_q     <= '0;
            end else if (rise_i) begin
                if (hunting_q) begin
                    if (din_i) begin
                        hunting_q <= 1'b0;
                        cnt_q     <= '0;
                    end
                end else begin
                    sh_q  <= {sh_q[FIELD_BITS-3:0], din_i};
                    cnt_q <= cnt_q + 1'b1;
                    if (cnt_q == CW'(FIELD_BITS - 1)) begin
                        hunting_q     <= 1'b1;
                        done_o        <= 1'b1;
                        ctrl_o.sel    <= sh_q[5:3];
                        ctrl_o.single <= sh_q[1];
                        ctrl_o.pm     <= pwr_mode_e'({sh_q[0], din_i});
                    end
                end
            end
        end
    end

    // R1
    done_after_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> $past(rise_i && cs_act_i && !hunting_q));
endmodule

// File: rtl/sarfe_pair_sel.sv
// Stand-in for the analog multiplexer and converter: picks the sample (or
// saturated difference of a pair) named by the channel code.
// Purely combinational; the caller registers the value.
module sarfe_pair_sel
    import sarfe_pkg::*;
#(
    parameter int SMP_W = 16
) (
    input  logic [2:0]                 sel_i,
    input  logic                       single_i,
    input  logic [SARFE_NCH*SMP_W-1:0] samples_i,
    output logic [SMP_W-1:0]           value_o
);
    localparam logic [SMP_W-1:0] POS_MAX = {1'b0, {(SMP_W-1){1'b1}}};
    localparam logic [SMP_W-1:0] NEG_MIN = {1'b1, {(SMP_W-1){1'b0}}};

    logic [1:0]       pos, neg;
    logic [SMP_W-1:0] a, b;
    logic [SMP_W:0]   diff;

    // Input routing and saturating subtract
    always_comb begin
        pos  = pos_index(sel_i);
        neg  = pos ^ 2'b01;
        a    = samples_i[pos*SMP_W +: SMP_W];
        b    = samples_i[neg*SMP_W +: SMP_W];
        diff = {a[SMP_W-1], a} - {b[SMP_W-1], b};
        if (!code_valid(sel_i)) begin
            value_o = '0;
        end else if (single_i) begin
            value_o = a;
        end else if (diff[SMP_W] != diff[SMP_W-1]) begin
            value_o = diff[SMP_W] ? NEG_MIN : POS_MAX;
        end else begin
            value_o = diff[SMP_W-1:0];
        end
    end
endmodule

// File: rtl/sarfe_seq.sv
// Conversion sequencer: holds the clock-mode register, runs the external or
// internal conversion, drives busy and the serial output shifter.
// Assumes done_i and serial-clock strobes never fall in the same cycle.
module sarfe_seq
    import sarfe_pkg::*;
#(
    parameter int SMP_W       = 16,
    parameter int CONV_CYCLES = 40
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fall_i,
    input  logic             cs_act_i,
    input  logic             cs_fall_i,
    input  logic             done_i,
    input  pwr_mode_e        pm_i,
    input  logic [SMP_W-1:0] value_i,
    output logic             dout_o,
    output logic             busy_o,
    output logic             mode_int_o
);
    localparam int CNT_W = $clog2(CONV_CYCLES + 1);

    logic             mode_int_q, last_int_q, pend_q, arm_q, run_q;
    logic [CNT_W-1:0] cnt_q;
    logic [SMP_W-1:0] sh_q, conv_q;

    // Conversion control, busy flag and output shifter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_int_q <= 1'b0;
            last_int_q <= 1'b0;
            pend_q     <= 1'b0;
            arm_q      <= 1'b0;
            run_q      <= 1'b0;
            cnt_q      <= '0;
            sh_q       <= '0;
            conv_q     <= '0;
            busy_o     <= 1'b0;
            dout_o     <= 1'b0;
        end else begin
            if (done_i) begin
                conv_q     <= value_i;
                last_int_q <= mode_int_q;
                case (pm_i)
                    PM_INT_CLK: mode_int_q <= 1'b1;
                    PM_EXT_CLK: mode_int_q <= 1'b0;
                    default:    ;
                endcase
                if (mode_int_q) begin
                    run_q  <= 1'b1;
                    cnt_q  <= CNT_W'(CONV_CYCLES - 1);
                    busy_o <= 1'b0;
                    arm_q  <= 1'b0;
                end else begin
                    pend_q <= 1'b1;
                    run_q  <= 1'b0;
                end
            end else if (run_q) begin
                if (cnt_q == '0) begin
                    run_q  <= 1'b0;
                    busy_o <= 1'b1;
                    arm_q  <= 1'b1;
                end else begin
                    cnt_q <= cnt_q - 1'b1;
                end
            end

            if (!cs_act_i) begin
                dout_o <= 1'b0;
                sh_q   <= '0;
                pend_q <= 1'b0;
                if (!last_int_q) arm_q <= 1'b0;
            end else if (fall_i) begin
                if (arm_q) begin
                    dout_o <= conv_q[SMP_W-1];
                    sh_q   <= {conv_q[SMP_W-2:0], 1'b0};
                    arm_q  <= 1'b0;
                end else begin
                    dout_o <= sh_q[SMP_W-1];
                    sh_q   <= {sh_q[SMP_W-2:0], 1'b0};
                end
                if (pend_q) begin
                    busy_o <= 1'b1;
                    pend_q <= 1'b0;
                    arm_q  <= 1'b1;
                end else if (!last_int_q) begin
                    busy_o <= 1'b0;
                end
            end

            if (cs_fall_i && !mode_int_q) busy_o <= 1'b0;
        end
    end

    assign mode_int_o = mode_int_q;

    // R5
    ext_busy_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fall_i && cs_act_i && busy_o && !pend_q && !last_int_q && !done_i) |=> !busy_o);

    // R10
    int_busy_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
        run_q |-> !busy_o);

    // R9
    mode_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_i && (pm_i == PM_AUTO_OFF || pm_i == PM_RSVD)) |=> $stable(mode_int_q));

    // R8
    idle_dout_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_act_i |=> (!dout_o && !pend_q));
endmodule

// File: rtl/sar_serial_front.sv
// Top of the serial converter front-end: pin synchronizer, control receiver,
// input pairing stand-in and conversion sequencer. Output enables model the
// high-impedance states of the data and busy pins.
module sar_serial_front
    import sarfe_pkg::*;
#(
    parameter int SMP_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int CONV_CYCLES = 40
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       sclk_i,
    input  logic                       sel_n_i,
    input  logic                       sdi_i,
    input  logic [SARFE_NCH*SMP_W-1:0] smp_i,
    output logic                       sdo_o,
    output logic                       sdo_oe_o,
    output logic                       busy_o,
    output logic                       busy_oe_o
);
    logic             rise, fall, cs_act, cs_fall, din;
    logic             done, mode_int;
    ctrl_t            ctrl;
    logic [SMP_W-1:0] value;

    sarfe_pin_if #(.STAGES(SYNC_STAGES)) pins_i (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk_i), .sel_n_i(sel_n_i),
        .sdi_i(sdi_i), .rise_o(rise), .fall_o(fall), .cs_act_o(cs_act),
        .cs_fall_o(cs_fall), .din_o(din)
    );

    sarfe_ctrl_rx rx_i (
        .clk(clk), .rst_n(rst_n), .rise_i(rise), .cs_act_i(cs_act),
        .din_i(din), .done_o(done), .ctrl_o(ctrl)
    );

    sarfe_pair_sel #(.SMP_W(SMP_W)) mux_i (
        .sel_i(ctrl.sel), .single_i(ctrl.single), .samples_i(smp_i),
        .value_o(value)
    );

    sarfe_seq #(.SMP_W(SMP_W), .CONV_CYCLES(CONV_CYCLES)) seq_i (
        .clk(clk), .rst_n(rst_n), .fall_i(fall), .cs_act_i(cs_act),
        .cs_fall_i(cs_fall), .done_i(done), .pm_i(ctrl.pm),
        .value_i(value), .dout_o(sdo_o), .busy_o(busy_o),
        .mode_int_o(mode_int)
    );

    assign sdo_oe_o  = cs_act;
    assign busy_oe_o = cs_act || mode_int;
endmodule

// File: tb/sar_serial_front_tb.sv
`timescale 1ns/1ps
module sar_serial_front_tb_top;
    localparam int HP   = 6;
    localparam int CONV = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0;
    logic        sel_n = 1'b1;
    logic        sdi = 1'b0;
    logic [15:0] chv [4];
    logic [63:0] smp;
    logic        sdo, sdo_oe, busy, busy_oe;

    int errors = 0;
    int checks = 0;

    logic bitv  [0:80];
    logic obs_d [0:80];
    logic obs_b [0:80];

    always #10 clk = ~clk;

    assign smp = {chv[3], chv[2], chv[1], chv[0]};

    sar_serial_front #(.CONV_CYCLES(CONV)) dut_i (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sel_n_i(sel_n),
        .sdi_i(sdi), .smp_i(smp), .sdo_o(sdo), .sdo_oe_o(sdo_oe),
        .busy_o(busy), .busy_oe_o(busy_oe)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wait_clk(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_bits();
        for (int k = 0; k <= 80; k++) bitv[k] = 1'b0;
    endtask

    task automatic load_byte(input logic [7:0] b, input int at);
        for (int k = 0; k < 8; k++) bitv[at + k] = b[7 - k];
    endtask

    // One serial clock per bit: data, rise, fall, then sample outputs
    task automatic run(input int n);
        for (int k = 1; k <= n; k++) begin
            sdi = bitv[k];
            wait_clk(HP);
            sclk = 1'b1;
            wait_clk(HP);
            sclk = 1'b0;
            wait_clk(HP);
            obs_d[k] = sdo;
            obs_b[k] = busy;
        end
    endtask

    task automatic sel_low();
        sel_n = 1'b0;
        wait_clk(HP);
    endtask

    task automatic sel_high();
        sel_n = 1'b1;
        wait_clk(HP);
    endtask

    function automatic logic [15:0] word_at(input int s);
        logic [15:0] w;
        for (int j = 0; j < 16; j++) w[15 - j] = obs_d[s + j];
        return w;
    endfunction

    function automatic bit busy_only_at(input int a, input int b, input int n);
        bit ok = 1'b1;
        for (int k = 1; k <= n; k++)
            if (obs_b[k] != ((k == a) || (k == b))) ok = 1'b0;
        return ok;
    endfunction

    function automatic logic [15:0] exp_val(input logic [2:0] c, input logic se);
        int p, n, a, b, d;
        if (c == 3'b001) p = 0;
        else if (c == 3'b101) p = 1;
        else if (c == 3'b010) p = 2;
        else if (c == 3'b110) p = 3;
        else return 16'h0000;
        n = (p % 2 == 0) ? p + 1 : p - 1;
        a = int'($signed(chv[p]));
        b = int'($signed(chv[n]));
        if (se) return chv[p];
        d = a - b;
        if (d > 32767) d = 32767;
        if (d < -32768) d = -32768;
        return d[15:0];
    endfunction

    function automatic logic [7:0] mk(input logic [2:0] c, input logic se,
                                      input logic [1:0] pm);
        return {1'b1, c, 1'b0, se, pm};
    endfunction

    initial begin
        chv[0] = 16'h7000;
        chv[1] = 16'h9000;
        chv[2] = 16'h1234;
        chv[3] = 16'hFEDC;
        clear_bits();
        wait_clk(5);
        rst_n = 1'b1;
        wait_clk(4);

        // R8 reset state with select high
        chk(!sdo_oe && !busy_oe && !busy && !sdo, "R8 reset idle",
            {sdo_oe, busy_oe, busy, sdo}, 32'h0);

        // Sweep all channel codes in both input modes, external clock (R9 reset mode)
        for (int c = 0; c < 8; c++) begin
            for (int s = 0; s < 2; s++) begin
                logic [15:0] e;
                e = exp_val(3'(c), 1'(s));
                clear_bits();
                load_byte(mk(3'(c), 1'(s), 2'b11), 1);
                sel_low();
                run(26);
                sel_high();
                if ((c == 1 || c == 5 || c == 2 || c == 6) && s == 1)
                    chk(word_at(9) == e, "R2 single-ended word", word_at(9), e);
                else if (c == 1 || c == 5 || c == 2 || c == 6)
                    chk(word_at(9) == e, "R3 differential word", word_at(9), e);
                else
                    chk(word_at(9) == e, "R4 undefined code zero", word_at(9), e);
                chk(busy_only_at(8, 8, 26), "R5 busy one period", 0, 1);
                chk(!obs_d[25] && !obs_d[26], "R6 zero fill",
                    {obs_d[25], obs_d[26]}, 0);
            end
        end

        // R8 enables low after select rises in external mode
        chk(!sdo_oe && !busy_oe, "R8 tri-state", {sdo_oe, busy_oe}, 0);

        // R1 leading zeros ignored before start bit
        clear_bits();
        load_byte(mk(3'b110, 1'b1, 2'b11), 6);
        sel_low();
        run(31);
        sel_high();
        chk(busy_only_at(13, 13, 31), "R1 start hunt busy", 0, 1);
        chk(word_at(14) == 16'hFEDC, "R1 start hunt word", word_at(14), 16'hFEDC);

        // R1 partial byte abandoned by select high
        clear_bits();
        load_byte(mk(3'b001, 1'b1, 2'b11), 1);
        sel_low();
        run(4);
        sel_high();
        clear_bits();
        load_byte(mk(3'b010, 1'b1, 2'b11), 1);
        sel_low();
        run(26);
        sel_high();
        chk(word_at(9) == 16'h1234, "R1 abort then new byte", word_at(9), 16'h1234);

        // R7 overlapped frames
        clear_bits();
        load_byte(mk(3'b101, 1'b1, 2'b11), 1);
        load_byte(mk(3'b110, 1'b0, 2'b11), 17);
        sel_low();
        run(41);
        sel_high();
        chk(word_at(9) == 16'h9000, "R7 first word", word_at(9), 16'h9000);
        chk(busy_only_at(8, 24, 41), "R7 busy at 8 and 24", 0, 1);
        chk(word_at(25) == 16'hECA8, "R7 second word", word_at(25), 16'hECA8);
        chk(!obs_d[41], "R7 zero after second", obs_d[41], 0);

        // R9 internal mode requested: this conversion still external
        clear_bits();
        load_byte(mk(3'b001, 1'b1, 2'b10), 1);
        sel_low();
        run(26);
        chk(busy_only_at(8, 8, 26), "R9 deferred switch busy", 0, 1);
        chk(word_at(9) == 16'h7000, "R9 deferred switch word", word_at(9), 16'h7000);

        // R10 internal conversion, PD=00 keeps internal (R9)
        clear_bits();
        load_byte(mk(3'b001, 1'b0, 2'b00), 1);
        run(8);
        chk(!obs_b[8], "R10 busy low at start", obs_b[8], 0);
        wait_clk(CONV + 10);
        chk(busy, "R10 busy high when stored", busy, 1);
        clear_bits();
        run(17);
        chk(word_at(1) == 16'h7FFF, "R3 saturate high internal read", word_at(1), 16'h7FFF);
        chk(!obs_d[17], "R6 zero after internal read", obs_d[17], 0);

        // R11 reserved code keeps internal; select high during conversion
        clear_bits();
        load_byte(mk(3'b010, 1'b1, 2'b01), 1);
        run(8);
        chk(!obs_b[8], "R9 reserved keeps internal", obs_b[8], 0);
        sel_high();
        chk(busy_oe && !sdo_oe, "R11 busy driven with select high",
            {busy_oe, sdo_oe}, 2'b10);
        wait_clk(CONV + 10);
        chk(busy && busy_oe, "R11 busy high while deselected", {busy, busy_oe}, 2'b11);
        sel_low();
        clear_bits();
        run(17);
        chk(word_at(1) == 16'h1234, "R10 read after reselect", word_at(1), 16'h1234);

        // R9 PD=11 while internal: conversion internal, then external
        clear_bits();
        load_byte(mk(3'b110, 1'b1, 2'b11), 1);
        run(8);
        chk(!obs_b[8], "R9 still internal", obs_b[8], 0);
        wait_clk(CONV + 10);
        clear_bits();
        run(17);
        chk(word_at(1) == 16'hFEDC, "R10 internal word", word_at(1), 16'hFEDC);
        sel_high();
        chk(!busy_oe, "R8 busy tri-state back in external", busy_oe, 0);

        // R8 busy low after select falls; R9 external again; R3 saturate low
        sel_low();
        chk(!busy && busy_oe, "R8 busy low after select fall", {busy, busy_oe}, 2'b01);
        clear_bits();
        load_byte(mk(3'b101, 1'b0, 2'b11), 1);
        run(26);
        sel_high();
        chk(busy_only_at(8, 8, 26), "R9 external restored", 0, 1);
        chk(word_at(9) == 16'h8000, "R3 saturate low", word_at(9), 16'h8000);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        checks++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule